// File: doc/BRIEF.md
# Asynchronous Serial Receive Engine

This block turns one asynchronous serial line into parallel characters. It runs from the system clock. A one-cycle enable pulse arrives sixteen times per bit period, and all frame timing is measured in those pulses. The line is synchronised first. The engine then treats a low level seen in the idle state as a start edge and re-checks the line at the centre of the start bit. A start bit that has already returned high by then is dropped as a glitch. A confirmed start is followed by 5 to 8 data bits, an optional parity bit and one or two stop bits, each sampled at its centre.

Every finished character goes out on a registered byte bus together with three flags (parity error, framing error, line break) and a one-cycle valid strobe. A receive queue downstream captures it. The configuration inputs set the word length, the stop length, and the parity mode: none, even, odd or forced. They must stay stable while a character is being received. After a framing error or a break, the engine waits until the line is high again before it arms for the next start edge. This stops a held-low line from producing a stream of phantom characters.

Top module: `uart_rx_engine`

## Requirements
- R1: While reset is high and after it is released, `rx_valid` is low and `rx_data`, `rx_perr`, `rx_ferr` and `rx_brk` are zero. A line held low from reset onward produces no character until it has been high at least once.
- R2: In the idle state, a low line on a sample pulse starts a frame. The line is checked again 8 pulses later. If it is high, the frame is dropped, no character is delivered, and the engine returns to idle.
- R3: Data bits are sampled every 16 pulses after the start-bit centre, least significant bit first. `cfg_wlen` gives the word length: 0 means 5, 1 means 6, 2 means 7, 3 means 8 data bits. Unused upper bits of `rx_data` are zero.
- R4: With `cfg_par_en` = 0, no parity bit is expected and `rx_perr` stays 0. With parity on and `cfg_par_force` = 0, `cfg_par_even` = 1 expects an even count of ones over data and parity, and 0 expects an odd count. A mismatch sets `rx_perr`.
- R5: With `cfg_par_en` = 1 and `cfg_par_force` = 1, the parity bit must equal the inverse of `cfg_par_even`. Any other value sets `rx_perr`.
- R6: A first stop bit sampled as 0 sets `rx_ferr`.
- R7: With `cfg_two_stop` = 1 and a word length of 6 to 8, a second stop bit is sampled at its centre, and a 0 there also sets `rx_ferr`. With a 5-bit word, `cfg_two_stop` selects one and a half stop bits, and only the first stop bit is checked.
- R8: When the data bits, the parity bit (if present) and every sampled stop bit are all 0, one character is delivered with `rx_data` = 0, `rx_brk` = 1 and `rx_ferr` = 1. A character with any 1 among those bits has `rx_brk` = 0.
- R9: After a character with `rx_ferr` = 1, a line that stays low starts no new frame. The engine arms again only after it has sampled the line high.
- R10: `rx_valid` is high for exactly one clock per character. It rises on the clock after the sample pulse of the last stop bit, and the flags are valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_16x | input | 1 | Sample enable, 16 pulses per bit period |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| cfg_wlen | input | 2 | Word length code, 0..3 gives 5..8 bits |
| cfg_two_stop | input | 1 | 1: two stop bits (one and a half for 5-bit words) |
| cfg_par_en | input | 1 | 1: a parity bit follows the data |
| cfg_par_even | input | 1 | 1: even parity, 0: odd parity |
| cfg_par_force | input | 1 | 1: parity bit is a fixed level, the inverse of cfg_par_even |
| rx_data | output | 8 | Received character, right aligned |
| rx_perr | output | 1 | Parity error for this character |
| rx_ferr | output | 1 | Framing error for this character |
| rx_brk | output | 1 | Line break detected |
| rx_valid | output | 1 | One-cycle strobe for a finished character |

## Verification
A phase counter that is off by one moves every sampling point. A shifted sample shows up as a corrupted byte or as a spurious parity or framing flag on the very next character, so each transmitted frame is compared field by field against a value computed from the bits the bench itself put on the line. State errors show up within a frame time or two. An engine that fails to wait for a high line produces extra break characters while the line is held low. One that fails to drop glitches produces a character the scoreboard never queued. Both leave the expected queue out of step, and the final empty-queue check reports it.

// File: rtl/srx_pkg.sv
package srx_pkg;
  // receive state; order is free, nothing outside decodes it
  typedef enum logic [2:0] {
    ST_WAIT_HIGH = 3'd0,
    ST_IDLE      = 3'd1,
    ST_START     = 3'd2,
    ST_DATA      = 3'd3,
    ST_PAR       = 3'd4,
    ST_STOP1     = 3'd5,
    ST_STOP2     = 3'd6
  } srx_state_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  // during reset the chain follows the line so that no false edge appears at release
  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) chain <= din;
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{din}};
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/srx_parity.sv
module srx_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              even_sel,
  input  logic              force_sel,
  output logic              exp_bit
);
  always_comb begin
    if (force_sel)     exp_bit = ~even_sel;
    else if (even_sel) exp_bit = ^data;
    else               exp_bit = ~^data;
  end
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  parameter int WLEN_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rx_s,
  input  logic [WLEN_W-1:0] cfg_wlen,
  input  logic              cfg_two_stop,
  input  logic              cfg_par_en,
  input  logic              par_exp,
  output logic [DATA_W-1:0] asm_data,
  output logic [DATA_W-1:0] out_data,
  output logic              out_perr,
  output logic              out_ferr,
  output logic              out_brk,
  output logic              out_valid
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int MIN_W = DATA_W - (1 << WLEN_W) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2 - 1);

  srx_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  bidx;
  logic [DATA_W-1:0] shreg;
  logic              par_bit;
  logic              stop1_bad;

  logic [IDX_W-1:0]  nbits_m1;
  logic              use_two, last_stop, all_bad, any_bad;
  logic              ferr_c, brk_c, perr_c;

  always_comb begin
    nbits_m1  = IDX_W'(MIN_W - 1) + IDX_W'(cfg_wlen);
    asm_data  = shreg >> (IDX_W'(DATA_W - 1) - nbits_m1);
    use_two   = cfg_two_stop && (cfg_wlen != '0);
    last_stop = (state == ST_STOP2) || (state == ST_STOP1 && !use_two);
    all_bad   = (state == ST_STOP2) ? (stop1_bad && !rx_s) : !rx_s;
    any_bad   = (state == ST_STOP2) ? (stop1_bad || !rx_s) : !rx_s;
    ferr_c    = any_bad;
    brk_c     = all_bad && (asm_data == '0) && !(cfg_par_en && par_bit);
    perr_c    = cfg_par_en && (par_bit != par_exp);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_WAIT_HIGH;
      cnt       <= '0;
      bidx      <= '0;
      shreg     <= '0;
      par_bit   <= 1'b0;
      stop1_bad <= 1'b0;
      out_data  <= '0;
      out_perr  <= 1'b0;
      out_ferr  <= 1'b0;
      out_brk   <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (tick) begin
        case (state)
          ST_WAIT_HIGH: if (rx_s) state <= ST_IDLE;
          ST_IDLE: begin
            if (!rx_s) begin
              state <= ST_START;
              cnt   <= '0;
            end
          end
          ST_START: begin
            if (cnt == MID) begin
              cnt   <= '0;
              bidx  <= '0;
              shreg <= '0;
              state <= rx_s ? ST_IDLE : ST_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: begin
            if (cnt != LAST) begin
              cnt <= cnt + 1'b1;
            end else begin
              cnt <= '0;
              case (state)
                ST_DATA: begin
                  shreg <= {rx_s, shreg[DATA_W-1:1]};
                  if (bidx == nbits_m1) state <= cfg_par_en ? ST_PAR : ST_STOP1;
                  else                  bidx  <= bidx + 1'b1;
                end
                ST_PAR: begin
                  par_bit <= rx_s;
                  state   <= ST_STOP1;
                end
                ST_STOP1: begin
                  stop1_bad <= !rx_s;
                  if (use_two) state <= ST_STOP2;
                end
                default: ;
              endcase
              if (last_stop) begin
                out_valid <= 1'b1;
                out_data  <= asm_data;
                out_perr  <= perr_c;
                out_ferr  <= ferr_c;
                out_brk   <= brk_c;
                state     <= ferr_c ? ST_WAIT_HIGH : ST_IDLE;
              end
            end
          end
        endcase
      end
    end
  end

  // R10
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R8
  break_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_brk) |-> (out_data == '0 && out_ferr));

  // R9
  wait_high_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_HIGH && !rx_s) |=> (state == ST_WAIT_HIGH));

  // R2
  false_start_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START && tick && cnt == MID && rx_s) |=> (state == ST_IDLE && !out_valid));

  // R4
  no_parity_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(cfg_par_en)) |-> !out_perr);

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(cfg_wlen) == '0) |-> (out_data[DATA_W-1:MIN_W] == '0));
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine #(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int WLEN_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_16x,
  input  logic              rx_in,
  input  logic [WLEN_W-1:0] cfg_wlen,
  input  logic              cfg_two_stop,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_par_force,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_perr,
  output logic              rx_ferr,
  output logic              rx_brk,
  output logic              rx_valid
);
  logic              rx_s;
  logic              par_exp;
  logic [DATA_W-1:0] asm_data;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rx_in),
    .dout (rx_s)
  );

  srx_parity #(.DATA_W(DATA_W)) u_parity (
    .data      (asm_data),
    .even_sel  (cfg_par_even),
    .force_sel (cfg_par_force),
    .exp_bit   (par_exp)
  );

  srx_frame #(.DATA_W(DATA_W), .OSR(OSR), .WLEN_W(WLEN_W)) u_frame (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick_16x),
    .rx_s         (rx_s),
    .cfg_wlen     (cfg_wlen),
    .cfg_two_stop (cfg_two_stop),
    .cfg_par_en   (cfg_par_en),
    .par_exp      (par_exp),
    .asm_data     (asm_data),
    .out_data     (rx_data),
    .out_perr     (rx_perr),
    .out_ferr     (rx_ferr),
    .out_brk      (rx_brk),
    .out_valid    (rx_valid)
  );
endmodule

// File: tb/test_uart_rx_engine.sv
module test_uart_rx_engine;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       rx = 1'b0;
  logic [1:0] cfg_wlen = 2'd3;
  logic       cfg_two_stop = 1'b0, cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_par_force = 1'b0;
  logic [7:0] rx_data;
  logic       rx_perr, rx_ferr, rx_brk, rx_valid;

  int n_chk = 0, n_fail = 0, tdiv = 0;
  logic [10:0] exp_q[$];
  string       tag_q[$];
  logic [10:0] e_item, a_item;
  string       e_tag;
  logic        prev_v = 1'b0;

  uart_rx_engine i_uart_rx_engine (
    .clk(clk), .rst(rst), .tick_16x(tick), .rx_in(rx),
    .cfg_wlen(cfg_wlen), .cfg_two_stop(cfg_two_stop), .cfg_par_en(cfg_par_en),
    .cfg_par_even(cfg_par_even), .cfg_par_force(cfg_par_force),
    .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rx_valid(rx_valid)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (tdiv == DIV - 1) begin tdiv <= 0; tick <= 1'b1; end
    else begin tdiv <= tdiv + 1; tick <= 1'b0; end
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: pop and compare {data, perr, ferr, brk}
  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      chk(!prev_v, "R10", "valid longer than one cycle", prev_v, 0);
      a_item = {rx_data, rx_perr, rx_ferr, rx_brk};
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2", "unexpected character", a_item, 0);
      end else begin
        e_item = exp_q.pop_front();
        e_tag  = tag_q.pop_front();
        chk(a_item == e_item, e_tag, "character {data,perr,ferr,brk}", a_item, e_item);
      end
    end
    prev_v = rx_valid;
  end

  task automatic line(logic b, int nt);
    rx = b;
    repeat (nt * DIV) @(negedge clk);
  endtask

  task automatic send(string tag, logic [7:0] d, int nb, bit pen, bit peven, bit pforce,
                      bit pflip, bit two, bit s1, bit s2, int low_after);
    logic [7:0] dm;
    logic       pbit, chk2, pe, fe, brk;
    dm = d & 8'((1 << nb) - 1);
    cfg_wlen = 2'(nb - 5);
    cfg_two_stop = two; cfg_par_en = pen; cfg_par_even = peven; cfg_par_force = pforce;
    pbit = pforce ? ~peven : (peven ? ^dm : ~^dm);
    pbit = pbit ^ pflip;
    chk2 = two && (nb > 5);
    pe   = pen && pflip;
    fe   = !s1 || (chk2 && !s2);
    brk  = (dm == 8'd0) && (!pen || !pbit) && !s1 && (!chk2 || !s2);
    exp_q.push_back({dm, pe, fe, brk});
    tag_q.push_back(tag);
    line(1'b0, 16);
    for (int i = 0; i < nb; i++) line(dm[i], 16);
    if (pen) line(pbit, 16);
    line(s1, 16);
    if (chk2) line(s2, 16);
    if (low_after > 0) line(1'b0, low_after);
    line(1'b1, 40);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    chk(rx_valid == 1'b0, "R1", "valid in reset", rx_valid, 0);
    chk({rx_data, rx_perr, rx_ferr, rx_brk} == 11'd0, "R1", "outputs in reset",
        {rx_data, rx_perr, rx_ferr, rx_brk}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({rx_valid, rx_data, rx_perr, rx_ferr, rx_brk} == 12'd0, "R1", "outputs after reset",
        {rx_valid, rx_data, rx_perr, rx_ferr, rx_brk}, 0);
    // R1: line low from reset onward, no character may appear
    line(1'b0, 48);
    line(1'b1, 24);
    // R3 word lengths, no parity
    send("R3", 8'hA5, 8, 0, 0, 0, 0, 0, 1, 1, 0);
    send("R3", 8'h5A, 7, 0, 0, 0, 0, 0, 1, 1, 0);
    send("R3", 8'h13, 5, 0, 0, 0, 0, 0, 1, 1, 0);
    // R4 parity modes
    send("R4", 8'h2C, 6, 1, 1, 0, 0, 0, 1, 1, 0);
    send("R4", 8'h81, 8, 1, 0, 0, 0, 0, 1, 1, 0);
    send("R4", 8'h7E, 8, 1, 1, 0, 1, 0, 1, 1, 0);
    // R5 forced parity
    send("R5", 8'h0F, 8, 1, 1, 1, 0, 0, 1, 1, 0);
    send("R5", 8'hF0, 8, 1, 0, 1, 1, 0, 1, 1, 0);
    // R6 / R9: bad stop, line held low afterwards
    send("R6", 8'h3C, 8, 0, 0, 0, 0, 0, 0, 1, 20);
    // R7 two stop bits
    send("R7", 8'h55, 8, 0, 0, 0, 0, 1, 1, 0, 0);
    send("R7", 8'h99, 8, 0, 0, 0, 0, 1, 1, 1, 0);
    // R7 / R2: 5-bit, 1.5 stop, short low afterwards is a rejected start
    send("R7", 8'h0A, 5, 0, 0, 0, 0, 1, 1, 1, 6);
    // R2 glitch then a good character
    line(1'b0, 3);
    line(1'b1, 32);
    send("R2", 8'hC3, 8, 0, 0, 0, 0, 0, 1, 1, 0);
    // R8 / R9 break held low
    send("R8", 8'h00, 8, 1, 1, 0, 0, 0, 0, 0, 60);
    send("R8", 8'h00, 8, 0, 0, 0, 0, 0, 1, 1, 0);
    repeat (200) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "characters not delivered", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule